// File: doc/BRIEF.md
# In-Order Retirement Window with Speculative Discard

This block is the result-ordering window of a small out-of-order core. The issue stage places up to four instructions per clock into a circular buffer in program order. Each new instruction gets back a slot tag. Execution units later return results against those tags in any order. The window hands results to the architectural register file only in program order, at most two per clock.

Branches are tracked per entry. Retirement halts at any branch that has not yet resolved, so no result younger than an open prediction reaches architectural state. When a branch resolves as mispredicted, every entry behind it is dropped in that same clock and the corrected fetch address is presented one cycle later. A correctly predicted resolution simply lets the entries behind it drain.

The window also answers operand queries from the issue stage. For each issuing lane it reports whether the newest in-flight producer of a register already holds its value (with the value), is still executing, or does not exist.

Top module: `rob_window`

## Requirements
- R1: After reset the window is empty: no lane retires, no redirect is presented, no operand query hits, and a request for four slots is accepted.
- R2: An accepted request of N slots (0 to 4) occupies N consecutive slots in program order; issue lane i receives tag (tail + i) mod DEPTH, where tail is the slot after the youngest entry.
- R3: `alloc_ready` is low exactly when the free slot count is below `alloc_cnt`; a refused request occupies nothing.
- R4: A writeback to an occupied slot marks it complete with the returned value, in any order; a writeback to an unoccupied slot has no effect.
- R5: Retirement lane k is valid only when lanes 0..k-1 are valid and the entry k places behind the oldest is occupied and complete, so at most two entries leave per clock in program order.
- R6: Retirement stops at an unresolved branch; a resolved branch retires on its lane with `commit_wen` low.
- R7: A mispredicted resolution of an occupied, unresolved branch discards every younger entry, makes the slot after the branch the new tail, and raises `redirect_valid` with `redirect_pc` equal to `br_target` on the next cycle.
- R8: An allocation request presented in the same cycle as a mispredict discard is ignored.
- R9: An operand query names the newest occupied non-branch entry writing that register: `src_hit` with its value if complete, `src_busy` if not, both low if there is none.
- R10: Entries older than a mispredicted branch that are eligible to retire in the cycle of the discard still retire in that cycle.
- R11: A correctly predicted resolution raises no redirect and lets the entries behind the branch retire in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_cnt | input | 3 | Number of slots requested this cycle (0 to 4) |
| alloc_is_br | input | 4 | Per issue lane: instruction is a predicted branch |
| alloc_dst | input | 20 | Per issue lane: destination register (5 bits each) |
| alloc_ready | output | 1 | Enough free slots for the request |
| alloc_tag | output | 24 | Per issue lane: slot tag given out (6 bits each) |
| src_reg | input | 20 | Per issue lane: source register to look up |
| src_hit | output | 4 | Per lane: newest producer is complete |
| src_busy | output | 4 | Per lane: newest producer is still executing |
| src_val | output | 128 | Per lane: forwarded value, meaningful with `src_hit` |
| wb_valid | input | 2 | Per writeback port: result present |
| wb_tag | input | 12 | Per writeback port: slot tag |
| wb_val | input | 64 | Per writeback port: result value |
| br_valid | input | 1 | A branch resolution is presented |
| br_tag | input | 6 | Slot tag of the resolving branch |
| br_mispredict | input | 1 | The prediction was wrong |
| br_target | input | 32 | Corrected fetch address |
| redirect_valid | output | 1 | Fetch must restart (one cycle after discard) |
| redirect_pc | output | 32 | Address to restart fetch at |
| commit_valid | output | 2 | Per retirement lane: entry leaves this cycle |
| commit_wen | output | 2 | Per retirement lane: write the register file |
| commit_dst | output | 10 | Per retirement lane: destination register |
| commit_val | output | 64 | Per retirement lane: value to write |

## Verification
The hardest state to reach from the ports is a completely full window, with the refusal boundary at a few free slots and the pointers wrapping past the end of storage. Random traffic keeps the occupancy low because writebacks and retirement drain it. The stimulus therefore runs a phase that issues four plain instructions per cycle with no writebacks until requests are refused, and then drains. Mispredicts are also hard to combine with same-cycle retirement of older entries, so a late random phase raises the mispredict rate while writebacks stay frequent.

// File: rtl/rob_pkg.sv
package rob_pkg;
  // Per-slot status bits kept apart from the wide payload.
  typedef struct packed {
    logic valid;
    logic done;
    logic is_br;
    logic resolved;
  } rob_flags_t;
endpackage

// File: rtl/rob_retire.sv
module rob_retire
  import rob_pkg::*;
#(
  parameter int DEPTH    = 64,
  parameter int RETIRE_W = 2
) (
  input  rob_flags_t                        win [RETIRE_W],
  input  logic [$clog2(DEPTH):0]            occupancy,
  output logic [RETIRE_W-1:0]               take,
  output logic [$clog2(RETIRE_W+1)-1:0]     n_take
);
  localparam int PTR_W  = $clog2(DEPTH) + 1;
  localparam int RCNT_W = $clog2(RETIRE_W + 1);

  // Contiguous prefix of retire-eligible entries starting at the oldest.
  always_comb begin
    logic run;
    run    = 1'b1;
    n_take = '0;
    take   = '0;
    for (int k = 0; k < RETIRE_W; k++) begin
      run = run && (PTR_W'(k) < occupancy) && win[k].valid &&
            (win[k].is_br ? win[k].resolved : win[k].done);
      take[k] = run;
      if (run) n_take = n_take + RCNT_W'(1);
    end
  end
endmodule

// File: rtl/rob_lookup.sv
module rob_lookup
  import rob_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int AREG_W = 5,
  parameter int XLEN   = 32
) (
  input  logic [$clog2(DEPTH)-1:0] head_idx,
  input  rob_flags_t               flags [DEPTH],
  input  logic [AREG_W-1:0]        dsts  [DEPTH],
  input  logic [XLEN-1:0]          vals  [DEPTH],
  input  logic [AREG_W-1:0]        query,
  output logic                     hit,
  output logic                     busy,
  output logic [XLEN-1:0]          value
);
  localparam int IDX_W = $clog2(DEPTH);

  logic             found;
  logic [IDX_W-1:0] sel;
  logic [IDX_W-1:0] idx;

  // Walk from oldest to youngest; the last match is the newest producer.
  always_comb begin
    found = 1'b0;
    sel   = '0;
    idx   = '0;
    for (int a = 0; a < DEPTH; a++) begin
      idx = head_idx + IDX_W'(a);
      if (flags[idx].valid && !flags[idx].is_br && (dsts[idx] == query)) begin
        found = 1'b1;
        sel   = idx;
      end
    end
  end

  assign hit   = found &&  flags[sel].done;
  assign busy  = found && !flags[sel].done;
  assign value = vals[sel];
endmodule

// File: rtl/rob_window.sv
module rob_window
  import rob_pkg::*;
#(
  parameter int DEPTH    = 64,
  parameter int ISSUE_W  = 4,
  parameter int RETIRE_W = 2,
  parameter int WB_W     = 2,
  parameter int AREG_W   = 5,
  parameter int XLEN     = 32
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [$clog2(ISSUE_W+1)-1:0]       alloc_cnt,
  input  logic [ISSUE_W-1:0]                 alloc_is_br,
  input  logic [ISSUE_W*AREG_W-1:0]          alloc_dst,
  output logic                               alloc_ready,
  output logic [ISSUE_W*$clog2(DEPTH)-1:0]   alloc_tag,
  input  logic [ISSUE_W*AREG_W-1:0]          src_reg,
  output logic [ISSUE_W-1:0]                 src_hit,
  output logic [ISSUE_W-1:0]                 src_busy,
  output logic [ISSUE_W*XLEN-1:0]            src_val,
  input  logic [WB_W-1:0]                    wb_valid,
  input  logic [WB_W*$clog2(DEPTH)-1:0]      wb_tag,
  input  logic [WB_W*XLEN-1:0]               wb_val,
  input  logic                               br_valid,
  input  logic [$clog2(DEPTH)-1:0]           br_tag,
  input  logic                               br_mispredict,
  input  logic [XLEN-1:0]                    br_target,
  output logic                               redirect_valid,
  output logic [XLEN-1:0]                    redirect_pc,
  output logic [RETIRE_W-1:0]                commit_valid,
  output logic [RETIRE_W-1:0]                commit_wen,
  output logic [RETIRE_W*AREG_W-1:0]         commit_dst,
  output logic [RETIRE_W*XLEN-1:0]           commit_val
);
  localparam int IDX_W  = $clog2(DEPTH);
  localparam int PTR_W  = IDX_W + 1;
  localparam int CNT_W  = $clog2(ISSUE_W + 1);
  localparam int RCNT_W = $clog2(RETIRE_W + 1);

  // ---------------------------------------------------------------- state
  rob_flags_t        flg_q [DEPTH];
  rob_flags_t        flg_d [DEPTH];
  logic [AREG_W-1:0] dst_q [DEPTH];
  logic [AREG_W-1:0] dst_nx[DEPTH];
  logic [XLEN-1:0]   val_q [DEPTH];
  logic [XLEN-1:0]   val_nx[DEPTH];
  logic [DEPTH-1:0]  dst_we, val_we;
  logic [PTR_W-1:0]  head_q, head_d, tail_q, tail_d;
  logic              redir_q, redir_d;
  logic [XLEN-1:0]   rpc_q;
  logic              rpc_we;

  logic [IDX_W-1:0]  head_idx, tail_idx, br_age;
  logic [PTR_W-1:0]  occupancy, free_slots;
  logic              br_hit, flush, alloc_fire;

  rob_flags_t          win [RETIRE_W];
  logic [RETIRE_W-1:0] take;
  logic [RCNT_W-1:0]   n_take;

  assign head_idx   = head_q[IDX_W-1:0];
  assign tail_idx   = tail_q[IDX_W-1:0];
  assign occupancy  = tail_q - head_q;
  assign free_slots = PTR_W'(DEPTH) - occupancy;

  assign alloc_ready = PTR_W'(alloc_cnt) <= free_slots;
  assign br_hit      = br_valid && flg_q[br_tag].valid && flg_q[br_tag].is_br &&
                       !flg_q[br_tag].resolved;
  assign flush       = br_hit && br_mispredict;
  assign alloc_fire  = alloc_ready && (alloc_cnt != '0) && !flush;
  assign br_age      = br_tag - head_idx;

  // ------------------------------------------------------------- allocate
  for (genvar g = 0; g < ISSUE_W; g++) begin : g_tag
    assign alloc_tag[g*IDX_W +: IDX_W] = tail_idx + IDX_W'(g);
  end

  // ------------------------------------------------------- operand lookup
  for (genvar g = 0; g < ISSUE_W; g++) begin : g_lookup
    rob_lookup #(.DEPTH(DEPTH), .AREG_W(AREG_W), .XLEN(XLEN)) u_lookup (
      .head_idx (head_idx),
      .flags    (flg_q),
      .dsts     (dst_q),
      .vals     (val_q),
      .query    (src_reg[g*AREG_W +: AREG_W]),
      .hit      (src_hit[g]),
      .busy     (src_busy[g]),
      .value    (src_val[g*XLEN +: XLEN])
    );
  end

  // ----------------------------------------------------------- retirement
  always_comb begin
    for (int k = 0; k < RETIRE_W; k++) win[k] = flg_q[head_idx + IDX_W'(k)];
  end

  rob_retire #(.DEPTH(DEPTH), .RETIRE_W(RETIRE_W)) u_retire (
    .win       (win),
    .occupancy (occupancy),
    .take      (take),
    .n_take    (n_take)
  );

  for (genvar g = 0; g < RETIRE_W; g++) begin : g_commit
    logic [IDX_W-1:0] cidx;
    assign cidx = head_idx + IDX_W'(g);
    assign commit_valid[g]                = take[g];
    assign commit_wen[g]                  = take[g] && !flg_q[cidx].is_br;
    assign commit_dst[g*AREG_W +: AREG_W] = dst_q[cidx];
    assign commit_val[g*XLEN +: XLEN]     = val_q[cidx];
  end

  assign redirect_valid = redir_q;
  assign redirect_pc    = rpc_q;

  // ------------------------------------------------------------ next state
  always_comb begin
    logic [IDX_W-1:0] wt;
    logic [IDX_W-1:0] ai;
    flg_d   = flg_q;
    head_d  = head_q;
    tail_d  = tail_q;
    redir_d = 1'b0;
    rpc_we  = 1'b0;
    dst_we  = '0;
    val_we  = '0;
    wt      = '0;
    ai      = '0;
    for (int i = 0; i < DEPTH; i++) begin
      dst_nx[i] = '0;
      val_nx[i] = '0;
    end

    // writebacks, any order, only to occupied slots
    for (int w = 0; w < WB_W; w++) begin
      wt = wb_tag[w*IDX_W +: IDX_W];
      if (wb_valid[w] && flg_q[wt].valid) begin
        flg_d[wt].done = 1'b1;
        val_we[wt]     = 1'b1;
        val_nx[wt]     = wb_val[w*XLEN +: XLEN];
      end
    end

    // branch resolution
    if (br_hit) begin
      flg_d[br_tag].resolved = 1'b1;
      flg_d[br_tag].done     = 1'b1;
    end

    if (flush) begin
      // discard everything younger than the branch
      for (int a = 0; a < DEPTH; a++) begin
        if (IDX_W'(a) > br_age) flg_d[head_idx + IDX_W'(a)] = '0;
      end
      tail_d  = head_q + PTR_W'(br_age) + PTR_W'(1);
      redir_d = 1'b1;
      rpc_we  = 1'b1;
    end else if (alloc_fire) begin
      for (int i = 0; i < ISSUE_W; i++) begin
        if (CNT_W'(i) < alloc_cnt) begin
          ai = tail_idx + IDX_W'(i);
          flg_d[ai].valid    = 1'b1;
          flg_d[ai].done     = 1'b0;
          flg_d[ai].is_br    = alloc_is_br[i];
          flg_d[ai].resolved = 1'b0;
          dst_we[ai]         = 1'b1;
          dst_nx[ai]         = alloc_dst[i*AREG_W +: AREG_W];
        end
      end
      tail_d = tail_q + PTR_W'(alloc_cnt);
    end

    // retirement frees the oldest slots
    for (int k = 0; k < RETIRE_W; k++) begin
      if (take[k]) flg_d[head_idx + IDX_W'(k)] = '0;
    end
    head_d = head_q + PTR_W'(n_take);
  end

  // -------------------------------------------------------------- registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q  <= '0;
      tail_q  <= '0;
      redir_q <= 1'b0;
      rpc_q   <= '0;
      for (int i = 0; i < DEPTH; i++) flg_q[i] <= '0;
    end else begin
      head_q  <= head_d;
      tail_q  <= tail_d;
      redir_q <= redir_d;
      if (rpc_we) rpc_q <= br_target;
      for (int i = 0; i < DEPTH; i++) flg_q[i] <= flg_d[i];
    end
  end

  // payload storage: no reset, written under per-slot enables
  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (dst_we[i]) dst_q[i] <= dst_nx[i];
      if (val_we[i]) val_q[i] <= val_nx[i];
    end
  end
endmodule

// File: rtl/rob_window_chk.sv
module rob_window_chk #(
  parameter int DEPTH    = 64,
  parameter int ISSUE_W  = 4,
  parameter int RETIRE_W = 2
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic [$clog2(ISSUE_W+1)-1:0] alloc_cnt,
  input logic                         alloc_ready,
  input logic                         br_valid,
  input logic                         br_mispredict,
  input logic [$clog2(DEPTH):0]       head_q,
  input logic [$clog2(DEPTH):0]       tail_q,
  input logic [RETIRE_W-1:0]          commit_valid,
  input logic                         redirect_valid
);
  localparam int PTR_W = $clog2(DEPTH) + 1;

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (tail_q - head_q) <= PTR_W'(DEPTH));

  a_r3_refused_keeps_tail: assert property (@(posedge clk) disable iff (!rst_n)
    (!alloc_ready && !(br_valid && br_mispredict)) |=> tail_q == $past(tail_q));

  a_r2_tail_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_ready && !(br_valid && br_mispredict))
      |=> tail_q == $past(tail_q) + PTR_W'($past(alloc_cnt)));

  for (genvar k = 1; k < RETIRE_W; k++) begin : g_prefix
    a_r5_commit_prefix: assert property (@(posedge clk) disable iff (!rst_n)
      commit_valid[k] |-> commit_valid[k-1]);
  end

  a_r5_head_follows_commit: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> head_q == $past(head_q) + PTR_W'($countones($past(commit_valid))));

  a_r5_commit_within_occupancy: assert property (@(posedge clk) disable iff (!rst_n)
    PTR_W'($countones(commit_valid)) <= (tail_q - head_q));

  a_r7_redirect_cause: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |-> $past(br_valid && br_mispredict));
endmodule

bind rob_window rob_window_chk #(
  .DEPTH(DEPTH), .ISSUE_W(ISSUE_W), .RETIRE_W(RETIRE_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .alloc_cnt(alloc_cnt), .alloc_ready(alloc_ready),
  .br_valid(br_valid), .br_mispredict(br_mispredict), .head_q(head_q),
  .tail_q(tail_q), .commit_valid(commit_valid), .redirect_valid(redirect_valid)
);

// File: tb/tb_rob_window.sv
module tb_rob_window;
  localparam int DEPTH = 64, IW = 4, RW = 2, WW = 2, AW = 5, XL = 32, IDXW = 6, CW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [CW-1:0]      alloc_cnt = '0;
  logic [IW-1:0]      alloc_is_br = '0;
  logic [IW*AW-1:0]   alloc_dst = '0;
  logic               alloc_ready;
  logic [IW*IDXW-1:0] alloc_tag;
  logic [IW*AW-1:0]   src_reg = '0;
  logic [IW-1:0]      src_hit, src_busy;
  logic [IW*XL-1:0]   src_val;
  logic [WW-1:0]      wb_valid = '0;
  logic [WW*IDXW-1:0] wb_tag = '0;
  logic [WW*XL-1:0]   wb_val = '0;
  logic               br_valid = 1'b0, br_mispredict = 1'b0;
  logic [IDXW-1:0]    br_tag = '0;
  logic [XL-1:0]      br_target = '0;
  logic               redirect_valid;
  logic [XL-1:0]      redirect_pc;
  logic [RW-1:0]      commit_valid, commit_wen;
  logic [RW*AW-1:0]   commit_dst;
  logic [RW*XL-1:0]   commit_val;

  rob_window dut (.*);

  // reference state
  bit            m_v[DEPTH], m_d[DEPTH], m_b[DEPTH], m_r[DEPTH];
  logic [AW-1:0] m_dst[DEPTH];
  logic [XL-1:0] m_val[DEPTH];
  int unsigned   mh = 0, mt = 0;
  bit            exp_redir = 0, prev_flush_alloc = 0;
  logic [XL-1:0] exp_rpc = '0;
  string         redir_tag = "R7";
  int            mode = 0, p_misp = 20;
  int            n_chk = 0, n_bad = 0;
  bit            finished = 0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  function automatic int occ();
    return int'(mt - mh);
  endfunction

  task automatic drive();
    int cand[DEPTH];
    int n;
    int j0, j1;
    alloc_cnt   = (mode == 1) ? CW'(4) : (mode == 2) ? CW'(0) : CW'($urandom % 5);
    for (int i = 0; i < IW; i++) begin
      alloc_is_br[i] = (mode == 0) && ($urandom % 7 == 0);
      alloc_dst[i*AW +: AW] = AW'(1 + $urandom % 7);
      src_reg[i*AW +: AW]   = AW'($urandom % 8);
    end
    wb_valid = '0;
    br_valid = 1'b0;
    br_mispredict = 1'b0;
    br_target = $urandom;
    if (mode == 1) return;
    n = 0;
    for (int a = 0; a < occ(); a++) begin
      int idx = int'((mh + a) % DEPTH);
      if (m_v[idx] && !m_d[idx] && !m_b[idx]) begin cand[n] = idx; n++; end
    end
    if (n > 0 && $urandom % 4 != 0) begin
      j0 = $urandom % n;
      wb_valid[0] = 1'b1; wb_tag[0 +: IDXW] = IDXW'(cand[j0]); wb_val[0 +: XL] = $urandom;
      if (n > 1 && $urandom % 2 == 0) begin
        j1 = (j0 + 1 + $urandom % (n - 1)) % n;
        wb_valid[1] = 1'b1; wb_tag[IDXW +: IDXW] = IDXW'(cand[j1]); wb_val[XL +: XL] = $urandom;
      end
    end else if (occ() < DEPTH && $urandom % 8 == 0) begin
      // writeback aimed at an empty slot: must be ignored (R4)
      wb_valid[0] = 1'b1; wb_tag[0 +: IDXW] = IDXW'(mt % DEPTH); wb_val[0 +: XL] = $urandom;
    end
    n = 0;
    for (int a = 0; a < occ(); a++) begin
      int idx = int'((mh + a) % DEPTH);
      if (m_v[idx] && m_b[idx] && !m_r[idx]) begin cand[n] = idx; n++; end
    end
    if (n > 0 && $urandom % 3 == 0) begin
      br_valid = 1'b1;
      br_tag = IDXW'(cand[$urandom % n]);
      br_mispredict = ($urandom % 100) < p_misp;
    end
  endtask

  task automatic evaluate_and_update();
    int cnt = occ();
    bit flush_now, bhit, run;
    int ntake, age;
    bit tk[RW];
    string ctag;
    bhit = br_valid && m_v[br_tag] && m_b[br_tag] && !m_r[br_tag];
    flush_now = bhit && br_mispredict;

    chk("R3 ready", alloc_ready, (DEPTH - cnt) >= alloc_cnt);
    for (int i = 0; i < IW; i++)
      chk(prev_flush_alloc ? "R8 tag after ignored alloc" : "R2 tag",
          alloc_tag[i*IDXW +: IDXW], (mt + i) % DEPTH);

    run = 1; ntake = 0;
    for (int k = 0; k < RW; k++) begin
      int idx = int'((mh + k) % DEPTH);
      run = run && (k < cnt) && m_v[idx] && (m_b[idx] ? m_r[idx] : m_d[idx]);
      tk[k] = run;
      if (run) ntake++;
      ctag = flush_now ? "R10 retire during discard" : (m_b[idx] ? "R6 branch retire" : "R5 retire");
      chk(ctag, commit_valid[k], run);
      if (run) begin
        chk(ctag, commit_wen[k], !m_b[idx]);
        if (!m_b[idx]) begin
          chk(ctag, commit_dst[k*AW +: AW], m_dst[idx]);
          chk("R4 retired value", commit_val[k*XL +: XL], m_val[idx]);
        end
      end
    end

    for (int l = 0; l < IW; l++) begin
      bit found = 0;
      int fi = 0;
      for (int a = 0; a < cnt; a++) begin
        int idx = int'((mh + a) % DEPTH);
        if (m_v[idx] && !m_b[idx] && m_dst[idx] == src_reg[l*AW +: AW]) begin found = 1; fi = idx; end
      end
      chk("R9 hit", src_hit[l], found && m_d[fi]);
      chk("R9 busy", src_busy[l], found && !m_d[fi]);
      if (found && m_d[fi]) chk("R9 value", src_val[l*XL +: XL], m_val[fi]);
    end

    // state update in the order the requirements imply
    for (int w = 0; w < WW; w++) begin
      int t = int'(wb_tag[w*IDXW +: IDXW]);
      if (wb_valid[w] && m_v[t]) begin m_d[t] = 1; m_val[t] = wb_val[w*XL +: XL]; end
    end
    if (bhit) begin m_r[br_tag] = 1; m_d[br_tag] = 1; end
    if (flush_now) begin
      age = int'((br_tag - mh) % DEPTH);
      for (int a = age + 1; a < DEPTH; a++) begin
        int idx = int'((mh + a) % DEPTH);
        m_v[idx] = 0; m_d[idx] = 0; m_b[idx] = 0; m_r[idx] = 0;
      end
      mt = mh + age + 1;
    end else if (alloc_cnt != 0 && (DEPTH - cnt) >= alloc_cnt) begin
      for (int i = 0; i < alloc_cnt; i++) begin
        int idx = int'((mt + i) % DEPTH);
        m_v[idx] = 1; m_d[idx] = 0; m_b[idx] = alloc_is_br[i]; m_r[idx] = 0;
        m_dst[idx] = alloc_dst[i*AW +: AW];
      end
      mt = mt + alloc_cnt;
    end
    for (int k = 0; k < RW; k++) begin
      if (tk[k]) begin
        int idx = int'((mh + k) % DEPTH);
        m_v[idx] = 0; m_d[idx] = 0; m_b[idx] = 0; m_r[idx] = 0;
      end
    end
    mh = mh + ntake;
    exp_redir = flush_now;
    exp_rpc = br_target;
    redir_tag = (bhit && !br_mispredict) ? "R11 no redirect" : "R7 redirect";
    prev_flush_alloc = flush_now && (alloc_cnt != 0);
  endtask

  task automatic cycle();
    @(negedge clk);
    chk(redir_tag, redirect_valid, exp_redir);
    if (exp_redir) chk("R7 redirect pc", redirect_pc, exp_rpc);
    drive();
    #1;
    evaluate_and_update();
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    void'($urandom(32'h5eed_0a17));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    alloc_cnt = CW'(4);
    #1;
    chk("R1 ready after reset", alloc_ready, 1);
    chk("R1 no retire", commit_valid, 0);
    chk("R1 no redirect", redirect_valid, 0);
    chk("R1 no hit", src_hit | src_busy, 0);
    alloc_cnt = '0;

    mode = 0; p_misp = 20;
    repeat (3000) cycle();
    mode = 2;
    for (int c = 0; c < 400 && occ() != 0; c++) cycle();
    mode = 1;                       // fill to the brim (R3 boundary)
    repeat (24) cycle();
    chk("R3 full refuses", occ(), DEPTH);
    mode = 2;
    for (int c = 0; c < 400 && occ() != 0; c++) cycle();
    mode = 0; p_misp = 50;
    repeat (2000) cycle();
    mode = 2;
    for (int c = 0; c < 400 && occ() != 0; c++) cycle();
    cycle();
    summary();
  end

  initial begin
    #(4 * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
  end
endmodule